// File: doc/BRIEF.md
# USB Type-C Port Role and Source Attach Controller

This block is the digital core of a USB Type-C port. It settles which role the port takes: source-only, sink-only or dual-role. The role comes from a three-level strap that is latched once after reset. When the strap is left floating, a configuration register can override it. From that role the block drives the termination select for each of the two CC lines.

In the source role the block also runs the attach state machine. The CC comparator results arrive already digitized. When exactly one CC line shows a sink pull-down, and that indication stays steady for a programmable number of cycles, the port becomes attached. The block then drives an active-low attach flag low. If the other CC line shows a cable-powered load, the block enables VCONN on that other line.

A single register write port reaches one configuration byte. That byte holds a termination kill bit, the role override field and a current-advertisement field. The advertised current is the higher of the register field and a pin input.

Top module: `typec_role_ctrl`

## Requirements
- R1: The strap input `strapLevel` is decoded as follows. `2'b01` (driven high) selects source-only. `2'b00` (driven low) selects sink-only. `2'b10` and `2'b11` (floating) select dual-role.
- R2: The strap is latched on the first rising clock edge after `rstN` is released and held until the next reset, whatever the strap does later. Before that edge every output is inactive: both `termSel` are `2'b00`, `advLevel` is `2'b00`, `attachN` is 1 and both `vconnEn` are 0.
- R3: A write with `regAddr == 8'h0A` loads the configuration byte. Bits 5:4 are the role override, which takes effect only when the latched strap is floating: `2'b10` selects source, `2'b01` selects sink, and `2'b00` or `2'b11` selects dual-role. A driven strap ignores the field. Writes to any other address change nothing.
- R4: While configuration bit 0 is 1, both `termSel` are `2'b00`, `attachN` is 1, both `vconnEn` are 0 and `advLevel` is `2'b00`.
- R5: Termination codes are `2'b00` none, `2'b01` pull-up and `2'b10` pull-down. In the source role both lines get the pull-up. In the sink and dual-role roles both lines get the pull-down.
- R6: In the active source role, `advLevel` is the larger of configuration bits 7:6 and `curPinIn`. The levels are `2'b00` default, `2'b01` medium and `2'b10` high, and a value of `2'b11` counts as `2'b10`. In every other role `advLevel` is `2'b00`.
- R7: CC status codes are `2'b00` open, `2'b01` pull-down seen, `2'b10` load seen and `2'b11` open. An active source attaches on the edge that completes `DEB_CYCLES` consecutive sampled cycles in which exactly one line reads pull-down and that line stays the same. From then on `attachN` is 0.
- R8: An attached source detaches on the edge that completes `DEB_CYCLES` consecutive sampled cycles in which its attached line does not read pull-down. After that edge `attachN` is 1 and VCONN is off. Leaving the active source role releases `attachN` and VCONN at once.
- R9: While attached, `vconnEn` is 1 only on the line that is not attached, and only while that line reads the load code `2'b10`.
- R10: Pull-down on both lines, or load on both lines, never leads to an attach, and VCONN stays off.
- R11: After reset the override field reads `2'b00`, the kill bit reads 0 and the advertisement field reads `2'b00`. A floating strap therefore gives dual-role, and a source gives the default level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| strapLevel | input | 2 | Digitized three-level role strap |
| ccStat0 | input | 2 | Comparator result for CC line 0 |
| ccStat1 | input | 2 | Comparator result for CC line 1 |
| curPinIn | input | 2 | Current-advertisement request from a pin |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register write address |
| regWrData | input | 8 | Register write data |
| termSel0 | output | 2 | Termination select, CC line 0 |
| termSel1 | output | 2 | Termination select, CC line 1 |
| advLevel | output | 2 | Advertised current level |
| attachN | output | 1 | Active-low attached-source flag |
| vconnEn0 | output | 1 | VCONN enable, CC line 0 |
| vconnEn1 | output | 1 | VCONN enable, CC line 1 |

## Verification
The assertions assume several things about the inputs. The CC status inputs are already synchronous to `clk`. They change at most once per cycle and never during the sampling edge. The strap is settled by the time reset is released. The VCONN property depends on the CC inputs staying coherent with the attached orientation, so the attached line keeps its pull-down code in any cycle where the other line shows a load.

The stimulus follows all of these rules. Every input changes only on the falling clock edge. The strap is set while reset is held. The random phase never shows the load code on the attached line while VCONN is expected on the other one. It rolls each CC line's status independently at a low rate, so steady stretches long enough to debounce occur often. Directed cases cover both-pull-down, both-load, ignored writes, strap changes after reset, and the kill-bit sequence.

// File: rtl/typec_pkg.sv
package typec_pkg;

  typedef enum logic [1:0] {
    ROLE_NONE = 2'd0,
    ROLE_SRC  = 2'd1,
    ROLE_SNK  = 2'd2,
    ROLE_DRP  = 2'd3
  } role_e;

  localparam logic [1:0] CC_OPEN = 2'b00;
  localparam logic [1:0] CC_RD   = 2'b01;
  localparam logic [1:0] CC_RA   = 2'b10;

  localparam logic [1:0] TERM_NONE = 2'b00;
  localparam logic [1:0] TERM_PU   = 2'b01;
  localparam logic [1:0] TERM_PD   = 2'b10;

  localparam logic [1:0] LVL_HIGH = 2'b10;

  // Strobes from the attach control to the termination datapath.
  typedef struct packed {
    logic attached;
    logic orientCc1;
  } ctrlStrobe_t;

  function automatic role_e decodeStrap(input logic [1:0] s);
    if (s[1])      return ROLE_DRP;
    else if (s[0]) return ROLE_SRC;
    else           return ROLE_SNK;
  endfunction

  function automatic role_e decodeMode(input logic [1:0] m);
    case (m)
      2'b10:   return ROLE_SRC;
      2'b01:   return ROLE_SNK;
      default: return ROLE_DRP;
    endcase
  endfunction

  function automatic logic [1:0] clampLevel(input logic [1:0] l);
    return (l == 2'b11) ? LVL_HIGH : l;
  endfunction

endpackage

// File: rtl/typec_attach_ctrl.sv
module typec_attach_ctrl
  import typec_pkg::*;
#(
  parameter int DEB_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        srcActive,
  input  logic [1:0]  ccStat0,
  input  logic [1:0]  ccStat1,
  output ctrlStrobe_t strobe
);

  localparam int CNT_W = $clog2(DEB_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(DEB_CYCLES);

  typedef enum logic {ST_UNATT, ST_ATT} attState_e;

  attState_e        state;
  logic             orientQ;
  logic             candOri;
  logic [CNT_W-1:0] cnt;

  logic             rd0, rd1, candNow, oriNow, lineLost;
  logic [CNT_W-1:0] seenNext, lostNext;

  always_comb begin
    rd0      = (ccStat0 == CC_RD);
    rd1      = (ccStat1 == CC_RD);
    candNow  = rd0 ^ rd1;
    oriNow   = rd1;
    lineLost = orientQ ? !rd1 : !rd0;
    seenNext = (cnt != '0 && oriNow == candOri) ? cnt + 1'b1 : CNT_W'(1);
    lostNext = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_UNATT;
      orientQ <= 1'b0;
      candOri <= 1'b0;
      cnt     <= '0;
    end else if (!srcActive) begin
      state <= ST_UNATT;
      cnt   <= '0;
    end else if (state == ST_UNATT) begin
      if (candNow) begin
        candOri <= oriNow;
        if (seenNext == CNT_END) begin
          state   <= ST_ATT;
          orientQ <= oriNow;
          cnt     <= '0;
        end else begin
          cnt <= seenNext;
        end
      end else begin
        cnt <= '0;
      end
    end else begin
      if (lineLost) begin
        if (lostNext == CNT_END) begin
          state <= ST_UNATT;
          cnt   <= '0;
        end else begin
          cnt <= lostNext;
        end
      end else begin
        cnt <= '0;
      end
    end
  end

  assign strobe.attached  = (state == ST_ATT);
  assign strobe.orientCc1 = orientQ;

  // R7: the debounce counter never passes its end value
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_END);

  // R7: entering attached needs exactly one pull-down on the previous sample
  assert_attach_after_single_rd_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.attached) |-> $past((ccStat0 == CC_RD) ^ (ccStat1 == CC_RD)));

  // R10: no attach straight out of a both-pull-down or both-load sample
  assert_no_attach_on_pair_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.attached) |-> !$past((ccStat0 == ccStat1) && (ccStat0 != CC_OPEN)));

  // R8: while still in source role, detach only follows a lost sample
  assert_detach_after_loss_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(strobe.attached) && $past(srcActive)) |->
      $past(strobe.orientCc1 ? (ccStat1 != CC_RD) : (ccStat0 != CC_RD)));

endmodule

// File: rtl/typec_term_dp.sv
module typec_term_dp
  import typec_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  CFG_ADDR = 8'h0A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        strapLevel,
  input  logic [1:0]        ccStat0,
  input  logic [1:0]        ccStat1,
  input  logic [1:0]        curPinIn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  ctrlStrobe_t       strobe,
  output logic              srcActive,
  output logic [1:0]        termSel0,
  output logic [1:0]        termSel1,
  output logic [1:0]        advLevel,
  output logic              attachN,
  output logic              vconnEn0,
  output logic              vconnEn1
);

  localparam int NUM_CC   = 2;
  localparam int KILL_BIT = 0;
  localparam int MODE_LSB = 4;
  localparam int CUR_LSB  = 6;

  logic       roleValid;
  role_e      strapRole;
  logic [1:0] modeFld;
  logic       killTerm;
  logic [1:0] curFld;

  role_e      effRole;
  logic [1:0] regLvl, pinLvl;
  logic       cfgHit;

  logic [1:0] ccArr   [NUM_CC];
  logic [1:0] termArr [NUM_CC];
  logic       vconnArr[NUM_CC];

  assign cfgHit = regWrEn && (regAddr == ADDR_W'(CFG_ADDR));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      roleValid <= 1'b0;
      strapRole <= ROLE_NONE;
      modeFld   <= 2'b00;
      killTerm  <= 1'b0;
      curFld    <= 2'b00;
    end else begin
      if (!roleValid) begin
        roleValid <= 1'b1;
        strapRole <= decodeStrap(strapLevel);
      end
      if (cfgHit) begin
        killTerm <= regWrData[KILL_BIT];
        modeFld  <= regWrData[MODE_LSB +: 2];
        curFld   <= regWrData[CUR_LSB +: 2];
      end
    end
  end

  always_comb begin
    effRole   = (strapRole == ROLE_DRP) ? decodeMode(modeFld) : strapRole;
    srcActive = roleValid && !killTerm && (effRole == ROLE_SRC);
    regLvl    = clampLevel(curFld);
    pinLvl    = clampLevel(curPinIn);
    advLevel  = !srcActive ? 2'b00 : ((regLvl > pinLvl) ? regLvl : pinLvl);
    attachN   = !(srcActive && strobe.attached);
  end

  assign ccArr[0] = ccStat0;
  assign ccArr[1] = ccStat1;

  for (genvar g = 0; g < NUM_CC; g++) begin : g_cc
    // the line not carrying the sink is the one whose index differs from orientation
    localparam logic OTHER_ORIENT = (g == 0);
    always_comb begin
      if (!roleValid || killTerm)
        termArr[g] = TERM_NONE;
      else if (effRole == ROLE_SRC)
        termArr[g] = TERM_PU;
      else
        termArr[g] = TERM_PD;
      vconnArr[g] = srcActive && strobe.attached &&
                    (strobe.orientCc1 == OTHER_ORIENT) && (ccArr[g] == CC_RA);
    end
  end

  assign termSel0 = termArr[0];
  assign termSel1 = termArr[1];
  assign vconnEn0 = vconnArr[0];
  assign vconnEn1 = vconnArr[1];

  // R2: latched role never changes after sampling
  assert_role_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    roleValid |=> (roleValid && $stable(strapRole)));

  // R2: nothing active before the strap has been sampled
  assert_idle_before_sample_R2: assert property (@(posedge clk) disable iff (!rstN)
    !roleValid |-> (termSel0 == TERM_NONE && termSel1 == TERM_NONE && attachN && !vconnEn0 && !vconnEn1));

  // R4: kill bit removes every termination
  assert_kill_clears_term_R4: assert property (@(posedge clk) disable iff (!rstN)
    killTerm |-> (termSel0 == TERM_NONE && termSel1 == TERM_NONE && attachN));

  // R9: VCONN on line 0 only with a load there and the sink on line 1
  assert_vconn0_side_R9: assert property (@(posedge clk) disable iff (!rstN)
    vconnEn0 |-> (ccStat0 == CC_RA && !attachN && termSel0 == TERM_PU));

  // R9: VCONN on line 1 only with a load there
  assert_vconn1_side_R9: assert property (@(posedge clk) disable iff (!rstN)
    vconnEn1 |-> (ccStat1 == CC_RA && !attachN && termSel1 == TERM_PU));

  // R6: the clamped level code never appears
  assert_adv_clamped_R6: assert property (@(posedge clk) disable iff (!rstN)
    advLevel != 2'b11);

endmodule

// File: rtl/typec_role_ctrl.sv
module typec_role_ctrl
  import typec_pkg::*;
#(
  parameter int         DEB_CYCLES = 16,
  parameter int         ADDR_W     = 8,
  parameter int         DATA_W     = 8,
  parameter logic [7:0] CFG_ADDR   = 8'h0A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        strapLevel,
  input  logic [1:0]        ccStat0,
  input  logic [1:0]        ccStat1,
  input  logic [1:0]        curPinIn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [1:0]        termSel0,
  output logic [1:0]        termSel1,
  output logic [1:0]        advLevel,
  output logic              attachN,
  output logic              vconnEn0,
  output logic              vconnEn1
);

  ctrlStrobe_t strobe;
  logic        srcActive;

  typec_attach_ctrl #(.DEB_CYCLES(DEB_CYCLES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .srcActive (srcActive),
    .ccStat0   (ccStat0),
    .ccStat1   (ccStat1),
    .strobe    (strobe)
  );

  typec_term_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_ADDR(CFG_ADDR)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strapLevel (strapLevel),
    .ccStat0    (ccStat0),
    .ccStat1    (ccStat1),
    .curPinIn   (curPinIn),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .strobe     (strobe),
    .srcActive  (srcActive),
    .termSel0   (termSel0),
    .termSel1   (termSel1),
    .advLevel   (advLevel),
    .attachN    (attachN),
    .vconnEn0   (vconnEn0),
    .vconnEn1   (vconnEn1)
  );

endmodule

// File: tb/sim_typec_role_ctrl.sv
`timescale 1ns/1ps
module sim_typec_role_ctrl;

  localparam int DEB = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] strapLevel = 2'b00;
  logic [1:0] ccStat0 = 2'b00, ccStat1 = 2'b00, curPinIn = 2'b00;
  logic       regWrEn = 1'b0;
  logic [7:0] regAddr = 8'h00, regWrData = 8'h00;
  logic [1:0] termSel0, termSel1, advLevel;
  logic       attachN, vconnEn0, vconnEn1;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  typec_role_ctrl #(.DEB_CYCLES(DEB)) u0 (
    .clk(clk), .rstN(rstN), .strapLevel(strapLevel), .ccStat0(ccStat0), .ccStat1(ccStat1),
    .curPinIn(curPinIn), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .termSel0(termSel0), .termSel1(termSel1), .advLevel(advLevel), .attachN(attachN),
    .vconnEn0(vconnEn0), .vconnEn1(vconnEn1)
  );

  // Behavioural expectation state. Roles: 0 none, 1 source, 2 sink, 3 dual.
  int mValid, mRole, mMode, mKill, mCur, mAtt, mOri, mCandOri, mCnt;

  function automatic int strapRoleOf(input logic [1:0] s);
    return s[1] ? 3 : (s[0] ? 1 : 2);
  endfunction

  function automatic int effRole();
    if (mRole != 3) return mRole;
    return (mMode == 2) ? 1 : ((mMode == 1) ? 2 : 3);
  endfunction

  function automatic bit srcOn();
    return mValid != 0 && mKill == 0 && effRole() == 1;
  endfunction

  function automatic int clampL(input int l);
    return (l == 3) ? 2 : l;
  endfunction

  function automatic int expTerm();
    if (mValid == 0 || mKill != 0) return 0;
    return (effRole() == 1) ? 1 : 2;
  endfunction

  function automatic int expAdv();
    int a, b;
    if (!srcOn()) return 0;
    a = clampL(mCur); b = clampL(int'(curPinIn));
    return (a > b) ? a : b;
  endfunction

  function automatic int expAttN();
    return (srcOn() && mAtt != 0) ? 0 : 1;
  endfunction

  function automatic int expVc(input int line);
    logic [1:0] st;
    st = (line == 0) ? ccStat0 : ccStat1;
    return (srcOn() && mAtt != 0 && mOri != line && st == 2'b10) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    int n;
    bit cand, ori, lost;
    if (rstN) begin
      if (!srcOn()) begin
        mAtt = 0; mCnt = 0;
      end else if (mAtt == 0) begin
        cand = (ccStat0 == 2'b01) ^ (ccStat1 == 2'b01);
        ori  = (ccStat1 == 2'b01);
        if (cand) begin
          n = (mCnt != 0 && int'(ori) == mCandOri) ? mCnt + 1 : 1;
          mCandOri = int'(ori);
          if (n == DEB) begin mAtt = 1; mOri = int'(ori); mCnt = 0; end
          else mCnt = n;
        end else mCnt = 0;
      end else begin
        lost = (mOri != 0) ? (ccStat1 != 2'b01) : (ccStat0 != 2'b01);
        if (lost) begin
          n = mCnt + 1;
          if (n == DEB) begin mAtt = 0; mCnt = 0; end
          else mCnt = n;
        end else mCnt = 0;
      end
      if (mValid == 0) begin mValid = 1; mRole = strapRoleOf(strapLevel); end
      if (regWrEn && regAddr == 8'h0A) begin
        mKill = int'(regWrData[0]); mMode = int'(regWrData[5:4]); mCur = int'(regWrData[7:6]);
      end
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  // Each output also carries the requirement that defines it.
  task automatic checkAll(input string tag);
    chk({tag, "/R5"}, "termSel0", int'(termSel0), expTerm());
    chk({tag, "/R5"}, "termSel1", int'(termSel1), expTerm());
    chk({tag, "/R6"}, "advLevel", int'(advLevel), expAdv());
    chk({tag, "/R7"}, "attachN", int'(attachN), expAttN());
    chk({tag, "/R9"}, "vconnEn0", int'(vconnEn0), expVc(0));
    chk({tag, "/R9"}, "vconnEn1", int'(vconnEn1), expVc(1));
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    @(negedge clk);
    checkAll(tag);
  endtask

  task automatic ticks(input string tag, input int k);
    for (int i = 0; i < k; i++) tick(tag);
  endtask

  task automatic doReset(input logic [1:0] strap);
    @(negedge clk);
    rstN = 1'b0;
    regWrEn = 1'b0; ccStat0 = 2'b00; ccStat1 = 2'b00; curPinIn = 2'b00;
    strapLevel = strap;
    mValid = 0; mRole = 0; mMode = 0; mKill = 0; mCur = 0;
    mAtt = 0; mOri = 0; mCandOri = 0; mCnt = 0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R2: nothing active before the first sampling edge
    checkAll("R2");
  endtask

  task automatic wrCfg(input string tag, input logic [7:0] addr, input logic [7:0] data);
    regWrEn = 1'b1; regAddr = addr; regWrData = data;
    tick(tag);
    regWrEn = 1'b0;
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5eed_0c01);

    // Source strap: R1, R11 default advertisement
    doReset(2'b01);
    ticks("R1", 2);
    ticks("R11", 1);

    // Attach on line 0 after exactly DEB steady samples: R7
    ccStat0 = 2'b01;
    ticks("R7", DEB + 2);
    ccStat1 = 2'b10;
    ticks("R9", 2);
    ccStat1 = 2'b00;
    ticks("R9", 1);
    // brief loss shorter than the window keeps the attach: R8
    ccStat0 = 2'b00;
    ticks("R8", DEB - 1);
    ccStat0 = 2'b01;
    ticks("R8", 2);
    ccStat0 = 2'b00;
    ticks("R8", DEB + 1);

    // Attach on line 1, VCONN on line 0: R9
    ccStat1 = 2'b01;
    ticks("R7", DEB + 1);
    ccStat0 = 2'b10;
    ticks("R9", 3);
    ccStat1 = 2'b00; ccStat0 = 2'b00;
    ticks("R8", DEB + 1);

    // Orientation flip inside the window restarts the count: R7
    ccStat0 = 2'b01;
    ticks("R7", DEB - 2);
    ccStat0 = 2'b00; ccStat1 = 2'b01;
    ticks("R7", DEB + 1);
    ccStat1 = 2'b00;
    ticks("R8", DEB + 1);

    // Both pull-down, both load: R10
    ccStat0 = 2'b01; ccStat1 = 2'b01;
    ticks("R10", 3 * DEB);
    ccStat0 = 2'b10; ccStat1 = 2'b10;
    ticks("R10", 3 * DEB);
    ccStat0 = 2'b00; ccStat1 = 2'b00;

    // Advertisement from register and pin: R6
    wrCfg("R6", 8'h0A, 8'hC0);
    ticks("R6", 1);
    curPinIn = 2'b01;
    wrCfg("R6", 8'h0A, 8'h40);
    curPinIn = 2'b11;
    ticks("R6", 1);
    curPinIn = 2'b00;
    wrCfg("R6", 8'h0A, 8'h00);

    // Strap change after sampling is ignored: R2
    strapLevel = 2'b00;
    ticks("R2", 2);
    strapLevel = 2'b10;
    ticks("R2", 2);

    // Override ignored with a driven strap, other addresses ignored: R3
    wrCfg("R3", 8'h0A, 8'h10);
    ticks("R3", 1);
    wrCfg("R3", 8'h0B, 8'h01);
    ticks("R3", 2);
    wrCfg("R3", 8'h0A, 8'h00);

    // Kill bit while attached: R4
    ccStat0 = 2'b01; ccStat1 = 2'b10;
    ticks("R7", DEB + 1);
    wrCfg("R4", 8'h0A, 8'h01);
    ticks("R4", 3);
    wrCfg("R4", 8'h0A, 8'h00);
    ticks("R4", DEB + 1);
    ccStat0 = 2'b00; ccStat1 = 2'b00;
    ticks("R8", DEB + 1);

    // Sink strap: pull-down both, no advertisement, no attach: R5
    doReset(2'b00);
    curPinIn = 2'b10; ccStat0 = 2'b01;
    ticks("R5", DEB + 2);
    wrCfg("R3", 8'h0A, 8'h20);
    ticks("R3", 2);

    // Floating strap: dual-role by default, then the three-step switch: R11, R3
    doReset(2'b10);
    curPinIn = 2'b00;
    ticks("R11", 2);
    wrCfg("R3", 8'h0A, 8'h01);
    wrCfg("R3", 8'h0A, 8'h21);
    wrCfg("R3", 8'h0A, 8'h20);
    ticks("R3", 1);
    wrCfg("R3", 8'h0A, 8'h10);
    ticks("R3", 1);
    wrCfg("R3", 8'h0A, 8'h30);
    ticks("R3", 1);

    // Random phase as source through the override
    doReset(2'b11);
    wrCfg("R3", 8'h0A, 8'h20);
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 7) == 0) ccStat0 = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 7) == 0) ccStat1 = 2'($urandom_range(0, 3));
      // keep the attached line coherent while the other shows a load
      if (mAtt != 0 && mOri == 0 && ccStat0 == 2'b10) ccStat0 = 2'b01;
      if (mAtt != 0 && mOri == 1 && ccStat1 == 2'b10) ccStat1 = 2'b01;
      if ($urandom_range(0, 49) == 0) curPinIn = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 99) == 0) begin
        regWrEn = 1'b1;
        regAddr = ($urandom_range(0, 3) == 0) ? 8'h0C : 8'h0A;
        regWrData = {2'($urandom_range(0, 3)), 2'b10, 3'b000, 1'($urandom_range(0, 5) == 0)};
      end
      tick("R7");
      regWrEn = 1'b0;
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule